// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block watches one dedicated interrupt input and a bank of eighteen general-purpose pins and turns their activity into interrupt request lines for a small processor. Every input first crosses into the clock domain through a two-flop synchronizer. A third flop keeps the value from the cycle before, so edges are found by comparing the current sample with the previous one. The dedicated input can raise its request on a low level, on any change, on a falling edge or on a rising edge. A 2-bit sense field in the control register picks the mode.

The general pins are split into three groups: pins 7..0, pins 11..8 and pins 17..12. Each group has its own enable bit and its own per-pin mask register. An enabled change on any masked-in pin of an enabled group sets that group's pending flag. Edge and pin-change flags stay set until the processor pulses the matching acknowledge input. Every request line is gated by the processor's global interrupt-enable input. Software reaches the registers through a single-cycle register bus whose reads are combinational.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all request outputs are low.
- R2: Sense code 00 (bits 7:6 of the control register at address 0) selects low-level mode. `irq_ext` is high while the synchronized dedicated pin is low and falls once the pin returns high. Nothing is latched.
- R3: Sense code 01 selects any-change mode. A rise or a fall of the dedicated pin sets the pending flag.
- R4: Sense code 10 selects falling-edge mode. A rise has no effect.
- R5: Sense code 11 selects rising-edge mode. A fall has no effect.
- R6: A request output is high only while `gie` and the source's enable bit are both set. The enable bits sit in the interrupt-mask register at address 1: bit 0 for the dedicated pin, bit 4+g for group g. With `gie` low, a pending flag is kept and appears once `gie` rises. An event that occurs while the source is disabled is never recorded.
- R7: In edge modes a pulse lasting two clock cycles is captured. The pending output rises on the third rising clock edge after the input changes.
- R8: A change on a pin whose bit is set in its group's mask register (address 2+g, bit i = pin lo(g)+i) sets that group's pending flag, shown on `irq_grp[g]`. A change on a masked-off pin does not.
- R9: Changes in a disabled group are dropped. Enabling the group later raises no request from that earlier history.
- R10: An acknowledge pulse clears the matching pending flag. If a new event arrives in the same cycle as the acknowledge, the flag stays set.
- R11: Register map. At address 0 only bits 7:6 are stored. At address 1, bit 7 (reserved) and bits 3:1 read 0 and ignore writes. The mask registers at addresses 2, 3 and 4 hold 8, 4 and 6 bits, and their unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gie | input | 1 | Global interrupt enable from the processor |
| ext_pin | input | 1 | Dedicated interrupt input (asynchronous) |
| pc_pins | input | 18 | General pins watched for changes (asynchronous) |
| ack_ext | input | 1 | Acknowledge for the dedicated-pin request |
| ack_grp | input | 3 | Acknowledge for each pin-change group |
| irq_ext | output | 1 | Dedicated-pin request |
| irq_grp | output | 3 | Pin-change group requests |

## Verification
A vector table drives each sense code through both edge directions. A design that decoded the field in the wrong order would fire on the wrong edge, and one that latched low-level mode would keep `irq_ext` high after the pin recovers. Directed tests check that a design which records events while a source is disabled, or while a pin is masked off, fires as soon as the group is enabled. They also pulse an acknowledge in the exact cycle of a new change; a design that lets the acknowledge win loses that event. The pending output is sampled both before and after the third clock edge following a pin change, which catches a missing or extra synchronizer stage.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int NUM_GROUPS     = 3;
    localparam int NUM_PINS       = 18;
    localparam int REG_W          = 8;
    localparam int ADDR_W         = 3;
    localparam int SYNC_STAGES    = 2;

    localparam int CTRL_SENSE_LSB = 6;
    localparam int IMASK_EXT_BIT  = 0;
    localparam int IMASK_GRP_LSB  = 4;

    localparam int ADDR_CTRL      = 0;
    localparam int ADDR_IMASK     = 1;
    localparam int ADDR_PMASK0    = 2;

    // lowest pin index of group g
    function automatic int grp_lo(input int g);
        case (g)
            0:       return 0;
            1:       return 8;
            default: return 12;
        endcase
    endfunction

    // number of pins in group g
    function automatic int grp_w(input int g);
        case (g)
            0:       return 8;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] grp_mask(input int g);
        return (REG_W'(1) << grp_w(g)) - REG_W'(1);
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign cur = stg[STAGES-1];
endmodule

// File: rtl/extint_sense.sv
module extint_sense
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cur,
    input  logic   prev,
    input  sense_e mode,
    input  logic   en,
    input  logic   gie,
    input  logic   ack,
    output logic   irq
);
    logic evt, hit, pend_q;

    always_comb begin
        case (mode)
            SENSE_ANY:  evt = cur ^ prev;
            SENSE_FALL: evt = prev & ~cur;
            SENSE_RISE: evt = cur & ~prev;
            default:    evt = 1'b0;
        endcase
    end

    assign hit = en & evt;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= hit | (pend_q & ~ack);
    end

    assign irq = gie & en & ((mode == SENSE_LOW) ? ~cur : pend_q);

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ack) |=> pend_q);

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && ack && !hit) |=> !pend_q);
endmodule

// File: rtl/extint_group.sv
module extint_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] pmask,
    input  logic         en,
    input  logic         gie,
    input  logic         ack,
    output logic         irq
);
    logic hit, pend_q;

    assign hit = en & (|((cur ^ prev) & pmask));

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= hit | (pend_q & ~ack);
    end

    assign irq = gie & en & pend_q;

    // R9
    grp_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !pend_q) |=> !pend_q);

    // R8
    grp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == prev && !pend_q) |=> !pend_q);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  gie,
    input  logic                  ext_pin,
    input  logic [NUM_PINS-1:0]   pc_pins,
    input  logic                  ack_ext,
    input  logic [NUM_GROUPS-1:0] ack_grp,
    output logic                  irq_ext,
    output logic [NUM_GROUPS-1:0] irq_grp
);
    localparam int SW = NUM_PINS + 1;

    sense_e                  sense_q;
    logic                    ext_en_q;
    logic [NUM_GROUPS-1:0]   grp_en_q;
    logic [REG_W-1:0]        pmask_q [NUM_GROUPS];
    logic [SW-1:0]           s_cur, s_prev;

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q  <= SENSE_LOW;
            ext_en_q <= 1'b0;
            grp_en_q <= '0;
            for (int g = 0; g < NUM_GROUPS; g++) pmask_q[g] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL))
                sense_q <= sense_e'(reg_wdata[CTRL_SENSE_LSB +: 2]);
            if (reg_addr == ADDR_W'(ADDR_IMASK)) begin
                ext_en_q <= reg_wdata[IMASK_EXT_BIT];
                grp_en_q <= reg_wdata[IMASK_GRP_LSB +: NUM_GROUPS];
            end
            for (int g = 0; g < NUM_GROUPS; g++)
                if (reg_addr == ADDR_W'(ADDR_PMASK0 + g))
                    pmask_q[g] <= reg_wdata & grp_mask(g);
        end
    end

    // register reads
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL))
            reg_rdata[CTRL_SENSE_LSB +: 2] = sense_q;
        if (reg_addr == ADDR_W'(ADDR_IMASK)) begin
            reg_rdata[IMASK_EXT_BIT]                = ext_en_q;
            reg_rdata[IMASK_GRP_LSB +: NUM_GROUPS]  = grp_en_q;
        end
        for (int g = 0; g < NUM_GROUPS; g++)
            if (reg_addr == ADDR_W'(ADDR_PMASK0 + g))
                reg_rdata = pmask_q[g];
    end

    extint_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    ({ext_pin, pc_pins}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    extint_sense u_sense (
        .clk  (clk),
        .rst  (rst),
        .cur  (s_cur[NUM_PINS]),
        .prev (s_prev[NUM_PINS]),
        .mode (sense_q),
        .en   (ext_en_q),
        .gie  (gie),
        .ack  (ack_ext),
        .irq  (irq_ext)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int GW = grp_w(g);
        extint_group #(.W(GW)) u_grp (
            .clk   (clk),
            .rst   (rst),
            .cur   (s_cur[LO +: GW]),
            .prev  (s_prev[LO +: GW]),
            .pmask (pmask_q[g][GW-1:0]),
            .en    (grp_en_q[g]),
            .gie   (gie),
            .ack   (ack_grp[g]),
            .irq   (irq_grp[g])
        );
    end

    // R11
    imask_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(ADDR_IMASK)) |-> (reg_rdata[7] == 1'b0 && reg_rdata[3:1] == 3'b000));

    // R6
    gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !gie |-> (irq_ext == 1'b0 && irq_grp == '0));
endmodule

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        gie;
    logic        ext_pin;
    logic [17:0] pc_pins;
    logic        ack_ext;
    logic [2:0]  ack_grp;
    logic        irq_ext;
    logic [2:0]  irq_grp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    extint_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie),
        .ext_pin(ext_pin), .pc_pins(pc_pins), .ack_ext(ack_ext),
        .ack_grp(ack_grp), .irq_ext(irq_ext), .irq_grp(irq_grp)
    );

    // {sense[1:0], start level, end level, expected irq_ext}
    localparam logic [4:0] VEC [8] = '{
        5'b00_1_0_1,   // R2 low level asserts
        5'b00_0_1_0,   // R2 not latched
        5'b01_0_1_1,   // R3 any change, rise
        5'b01_1_0_1,   // R3 any change, fall
        5'b10_1_0_1,   // R4 falling fires
        5'b10_0_1_0,   // R4 rising ignored
        5'b11_0_1_1,   // R5 rising fires
        5'b11_1_0_0    // R5 falling ignored
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic pulse_ack_ext();
        ack_ext = 1'b1; tick(1); ack_ext = 1'b0;
    endtask

    task automatic pulse_ack_grp(input logic [2:0] m);
        ack_grp = m; tick(1); ack_grp = 3'b000;
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; gie = 1'b0;
        ext_pin = 1'b0; pc_pins = '0; ack_ext = 1'b0; ack_grp = '0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk("R1 reg reset", 3'(a), 8'h00);
        chk("R1 irq_ext reset", 32'(irq_ext), 32'd0);
        chk("R1 irq_grp reset", 32'(irq_grp), 32'd0);

        // R11 register map
        wr(3'd0, 8'hFF); rd_chk("R11 ctrl", 3'd0, 8'hC0);
        wr(3'd1, 8'hFF); rd_chk("R11 imask", 3'd1, 8'h71);
        wr(3'd2, 8'hFF); rd_chk("R11 pmask0", 3'd2, 8'hFF);
        wr(3'd3, 8'hFF); rd_chk("R11 pmask1", 3'd3, 8'h0F);
        wr(3'd4, 8'hFF); rd_chk("R11 pmask2", 3'd4, 8'h3F);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);

        // vector table: dedicated pin sense modes
        gie = 1'b1;
        wr(3'd1, 8'h01);
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, {VEC[i][4:3], 6'b0});
            ext_pin = VEC[i][2];
            tick(6);
            pulse_ack_ext();
            tick(1);
            ext_pin = VEC[i][1];
            tick(6);
            chk($sformatf("R2/R3/R4/R5 vector %0d", i), 32'(irq_ext), 32'(VEC[i][0]));
        end

        // R6 gie gating keeps pending
        wr(3'd0, 8'hC0);
        ext_pin = 1'b0; tick(6); pulse_ack_ext();
        gie = 1'b0;
        ext_pin = 1'b1; tick(6);
        chk("R6 gie low masks", 32'(irq_ext), 32'd0);
        gie = 1'b1; #1;
        chk("R6 pending kept", 32'(irq_ext), 32'd1);
        tick(1);
        // R6 disabled source records nothing
        ext_pin = 1'b0; tick(6); pulse_ack_ext();
        wr(3'd1, 8'h00);
        ext_pin = 1'b1; tick(6);
        chk("R6 disabled no irq", 32'(irq_ext), 32'd0);
        wr(3'd1, 8'h01); tick(2);
        chk("R6 no stale after enable", 32'(irq_ext), 32'd0);

        // R7 two-cycle pulse and latency (rising mode)
        ext_pin = 1'b0; tick(6); pulse_ack_ext(); tick(1);
        ext_pin = 1'b1; tick(2);
        chk("R7 not yet before 3rd edge", 32'(irq_ext), 32'd0);
        ext_pin = 1'b0; tick(1);
        chk("R7 pulse captured at 3rd edge", 32'(irq_ext), 32'd1);
        tick(4);
        pulse_ack_ext();
        // R7 falling two-cycle pulse
        wr(3'd0, 8'h80);
        ext_pin = 1'b1; tick(6); pulse_ack_ext(); tick(1);
        ext_pin = 1'b0; tick(2); ext_pin = 1'b1; tick(5);
        chk("R7 low pulse captured", 32'(irq_ext), 32'd1);
        pulse_ack_ext();

        // R8 group masks
        wr(3'd1, 8'h71);
        wr(3'd2, 8'h04);
        pc_pins[3] = 1'b1; tick(6);
        chk("R8 masked-off pin", 32'(irq_grp), 32'd0);
        pc_pins[2] = 1'b1; tick(6);
        chk("R8 group0 pin2", 32'(irq_grp), 32'b001);
        wr(3'd4, 8'h20);
        pc_pins[17] = 1'b1; tick(6);
        chk("R8 group2 pin17", 32'(irq_grp), 32'b101);
        pulse_ack_grp(3'b111); #1;
        chk("R10 ack clears groups", 32'(irq_grp), 32'd0);

        // R9 disabled group ignores, no stale fire
        wr(3'd1, 8'h01);
        wr(3'd3, 8'h0F);
        pc_pins[9] = 1'b1; tick(6);
        chk("R9 disabled group", 32'(irq_grp), 32'd0);
        wr(3'd1, 8'h21); tick(4);
        chk("R9 no stale fire", 32'(irq_grp), 32'd0);
        pc_pins[8] = 1'b1; tick(6);
        chk("R9 group1 enabled fires", 32'(irq_grp), 32'b010);

        // R10 event in the ack cycle keeps flag
        pc_pins[10] = 1'b1;
        tick(2);
        ack_grp = 3'b010;
        tick(1);
        ack_grp = 3'b000;
        tick(1);
        chk("R10 event beats ack", 32'(irq_grp[1]), 32'd1);
        pulse_ack_grp(3'b010); #1;
        chk("R10 plain ack clears", 32'(irq_grp[1]), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule